// File: doc/BRIEF.md
# Memory-Window Flash Read Engine

This block lets a host fetch serial flash contents as if the flash were ordinary memory. Software first stores a 16-bit read template (the upper half of a 32-bit memory-command word). Once the template is accepted, the engine is in memory mode. From then on, every word read on the window bus becomes one flash read frame. The frame's address is the bus offset, and the bytes that come back from the flash are packed into the bus data.

The stored template is replayed unchanged on every window access. It names:
- the read opcode;
- how many address bytes follow the opcode;
- how many intermediate (dummy) bytes come next;
- whether the data phase uses one, two or four lanes.

Leaving memory mode takes a status handshake. Software pulses a reset request, watches the busy status bit, and sees the mode bit drop when the busy bit drops. Only then does a new template take effect.

The flash clock runs at half the system clock in SPI mode 0: it idles low, outputs change while it is low, and inputs are sampled on its rising edge.

Top module: `xip_read_engine`

## Requirements
- R1: After reset, status is 0, chip select is high, the flash clock is low, no pin is driven and `win_ready` is low.
- R2: A template write with a valid word, made while memory mode is off and no reset is pending, sets status bit 0 in the next cycle. The word's fields are:
  - opcode in bits 31:24;
  - frame form in bits 23:21;
  - field form in bits 20:19;
  - intermediate byte count in bits 18:16.
- R3: A word whose frame form is outside 2..5 (0, 1, 6 or 7) is rejected and status bit 0 stays 0. Frame form 1 is opcode-only. A word whose field form is 2 or 3 is also rejected.
- R4: A window read while memory mode is off, or while a reset is pending, completes in the cycle after it is accepted. It returns zero data and chip select stays high.
- R5: A window read in memory mode drives one frame with the flash clock at half the system rate. Chip select goes low, then the opcode and then the low (frame form − 1) bytes of the offset are sent MSB first on `fl_io_out[0]`.
- R6: After the address, the frame spends (intermediate count × 8) serial clocks before the data phase.
- R7: The data phase width depends on the field form:
  - field form 0 samples `fl_io_in[1]` for 32 clocks;
  - field form 1 with `ctl_dual`=1 samples `fl_io_in[1:0]` for 16 clocks, bit 1 first in time order within a byte;
  - field form 1 with `ctl_dual`=0 samples `fl_io_in[3:0]` for 8 clocks.
- R8: The returned bytes are packed little-endian. The first byte received lands in `win_rdata[7:0]`, and each byte is received MSB first.
- R9: The bus read is held in a wait state until the last data sample. `win_ready` is then high for exactly one cycle, with chip select already high, 2×(total flash clocks)+1 cycles after the read was accepted.
- R10: A reset request sets status bit 4 in the next cycle. Bit 4 stays set for RST_CYCLES cycles, and status bits 4 and 0 clear in the same cycle.
- R11: A reset request during a frame drops chip select at once and completes the pending bus read in the next cycle with zero data.
- R12: A template write while memory mode is on or a reset is pending is ignored, so later reads use the old template.
- R13: Pins are driven (`fl_io_oe`=0001) only during the opcode, address and intermediate clocks, and never during data or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcmd_wr | input | 1 | Template write strobe |
| mcmd_word | input | 16 | Bits 31:16 of the memory-command word |
| ctl_dual | input | 1 | Wide-lane select: 1 dual, 0 quad |
| rst_req | input | 1 | Reset request pulse (write of status bit 4) |
| status | output | 8 | Bit 0 memory mode on, bit 4 reset pending |
| win_rd | input | 1 | Window read request, held until ready |
| win_addr | input | WIN_AW | Window offset, used as flash address |
| win_rdata | output | DATA_W | Read data, valid with win_ready |
| win_ready | output | 1 | One-cycle read completion |
| fl_sck | output | 1 | Flash clock |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_out | output | 4 | Flash data out |
| fl_io_oe | output | 4 | Flash pin output enables |
| fl_io_in | input | 4 | Flash data in |

## Verification
A corrupted template would show up as wrong bits on the first frame after it was armed. Because the flash model answers a wrong opcode with all-ones bytes and derives data from the address it actually received, a bad opcode, address width or lane choice surfaces as wrong bus data within one read. A broken clock or phase counter shows up either as a read whose latency differs from 2×(flash clocks)+1, or as output enables still on during the data phase. A stuck status or reset counter is seen within RST_CYCLES cycles: bit 4 holds for the wrong length, or bit 0 clears apart from it.

// File: rtl/xip_pkg.sv
`timescale 1ns/1ps
package xip_pkg;

  // Upper half of the memory-command word; the field layout is shared with
  // the command register and decoded bit-exact.
  typedef struct packed {
    logic [7:0] opcode;   // word bits 31:24
    logic [2:0] frame;    // word bits 23:21, 2..5 = 1..4 address bytes
    logic [1:0] field;    // word bits 20:19, 0 serial, 1 wide data
    logic [2:0] ilen;     // word bits 18:16, intermediate bytes
  } tmpl_t;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HDR  = 2'd1,
    SQ_GAP  = 2'd2,
    SQ_DATA = 2'd3
  } sq_e;

  function automatic logic tmpl_ok(input tmpl_t t);
    return (t.frame >= 3'd2) && (t.frame <= 3'd5) && (t.field <= 2'd1);
  endfunction

endpackage

// File: rtl/xip_template.sv
`timescale 1ns/1ps
module xip_template
  import xip_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [15:0]   word,
  input  logic          rst_req,
  output tmpl_t         tmpl,
  output logic          mem_on,
  output logic          rst_busy
);

  localparam int RW = $clog2(RST_CYCLES + 1);

  tmpl_t          tmpl_q, tmpl_d;
  logic           on_q, on_d;
  logic           busy_q, busy_d;
  logic [RW-1:0]  cnt_q, cnt_d;
  logic           tmpl_en;

  always_comb begin
    tmpl_d  = tmpl_t'(word);
    tmpl_en = 1'b0;
    on_d    = on_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    if (rst_req) begin
      busy_d = 1'b1;
      cnt_d  = RW'(RST_CYCLES);
    end else if (busy_q) begin
      if (cnt_q == RW'(1)) begin
        busy_d = 1'b0;
        on_d   = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - RW'(1);
      end
    end else if (wr && !on_q && tmpl_ok(tmpl_t'(word))) begin
      tmpl_en = 1'b1;
      on_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmpl_q <= '0;
      on_q   <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (tmpl_en) tmpl_q <= tmpl_d;
      on_q   <= on_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign tmpl     = tmpl_q;
  assign mem_on   = on_q;
  assign rst_busy = busy_q;

endmodule

// File: rtl/xip_frame_seq.sv
`timescale 1ns/1ps
module xip_frame_seq
  import xip_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [7:0]        opcode,
  input  logic [2:0]        addr_bytes,
  input  logic [2:0]        gap_bytes,
  input  lane_e             lane,
  input  logic [ADDR_W-1:0] addr,
  output lane_e             lane_o,
  output logic              smp_en,
  output logic              done,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe
);

  localparam int HDR_BITS = 8 + ADDR_W;
  localparam int GAP_MAX  = 7 * 8;
  localparam int CMAX_A   = (HDR_BITS > DATA_BITS) ? HDR_BITS : DATA_BITS;
  localparam int CMAX     = (CMAX_A > GAP_MAX) ? CMAX_A : GAP_MAX;
  localparam int CW       = $clog2(CMAX + 1);

  sq_e                 st_q, st_d;
  logic                ph_q, ph_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [HDR_BITS-1:0] sr_q, sr_d;
  lane_e               lane_q, lane_d;
  logic [2:0]          gap_q, gap_d;
  logic [ADDR_W-1:0]   addr_al;
  logic [CW-1:0]       hdr_clk, gap_clk, dat_clk;

  always_comb begin
    addr_al = addr << (ADDR_W - 8 * int'(addr_bytes));
    hdr_clk = CW'(8 + 8 * int'(addr_bytes));
    gap_clk = CW'(8 * int'(gap_q));
    dat_clk = CW'(DATA_BITS >> int'(lane_q));
  end

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    lane_d = lane_q;
    gap_d  = gap_q;
    smp_en = 1'b0;
    done   = 1'b0;
    if (abort) begin
      st_d = SQ_IDLE;
      ph_d = 1'b0;
    end else if (st_q == SQ_IDLE) begin
      if (start) begin
        st_d   = SQ_HDR;
        ph_d   = 1'b0;
        cnt_d  = hdr_clk - CW'(1);
        sr_d   = {opcode, addr_al};
        lane_d = lane;
        gap_d  = gap_bytes;
      end
    end else if (!ph_q) begin
      ph_d = 1'b1;
    end else begin
      ph_d = 1'b0;
      unique case (st_q)
        SQ_HDR: begin
          sr_d = sr_q << 1;
          if (cnt_q == '0) begin
            if (gap_q != 3'd0) begin
              st_d  = SQ_GAP;
              cnt_d = gap_clk - CW'(1);
            end else begin
              st_d  = SQ_DATA;
              cnt_d = dat_clk - CW'(1);
            end
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        SQ_GAP: begin
          if (cnt_q == '0) begin
            st_d  = SQ_DATA;
            cnt_d = dat_clk - CW'(1);
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        SQ_DATA: begin
          smp_en = 1'b1;
          if (cnt_q == '0) begin
            done = 1'b1;
            st_d = SQ_IDLE;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
      lane_q <= LANE_X1;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      lane_q <= lane_d;
      gap_q  <= gap_d;
    end
  end

  assign lane_o = lane_q;
  assign cs_n   = (st_q == SQ_IDLE);
  assign sck    = (st_q != SQ_IDLE) && ph_q;
  assign io_oe  = ((st_q == SQ_HDR) || (st_q == SQ_GAP)) ? 4'b0001 : 4'b0000;
  assign io_out = {3'b000, (st_q == SQ_HDR) && sr_q[HDR_BITS-1]};

endmodule

// File: rtl/xip_assembler.sv
`timescale 1ns/1ps
module xip_assembler
  import xip_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  lane_e             lane,
  input  logic [3:0]        io_in,
  output logic [DATA_W-1:0] word
);

  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] sr_q, sr_d;

  always_comb begin
    unique case (lane)
      LANE_X1: sr_d = {sr_q[DATA_W-2:0], io_in[1]};
      LANE_X2: sr_d = {sr_q[DATA_W-3:0], io_in[1:0]};
      default: sr_d = {sr_q[DATA_W-5:0], io_in[3:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (smp_en) begin
      sr_q <= sr_d;
    end
  end

  // First byte received sits at the top of the stream; map it to byte 0.
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign word[8*b +: 8] = sr_q[DATA_W - 8*(b+1) +: 8];
  end

endmodule

// File: rtl/xip_read_engine.sv
`timescale 1ns/1ps
module xip_read_engine
  import xip_pkg::*;
#(
  parameter int WIN_AW     = 24,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mcmd_wr,
  input  logic [15:0]       mcmd_word,
  input  logic              ctl_dual,
  input  logic              rst_req,
  output logic [7:0]        status,
  input  logic              win_rd,
  input  logic [WIN_AW-1:0] win_addr,
  output logic [DATA_W-1:0] win_rdata,
  output logic              win_ready,
  output logic              fl_sck,
  output logic              fl_cs_n,
  output logic [3:0]        fl_io_out,
  output logic [3:0]        fl_io_oe,
  input  logic [3:0]        fl_io_in
);

  localparam int FL_AW = 32;

  tmpl_t             tmpl;
  logic              mem_on, rst_busy;
  lane_e             lane_sel, lane_run;
  logic              smp_en, done;
  logic [DATA_W-1:0] word;
  logic              accept, start, quick;
  logic              busy_q, busy_d;
  logic              rdy_q, rdy_d;
  logic              zero_q, zero_d;

  xip_template #(.RST_CYCLES(RST_CYCLES)) u_tmpl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (mcmd_wr),
    .word     (mcmd_word),
    .rst_req  (rst_req),
    .tmpl     (tmpl),
    .mem_on   (mem_on),
    .rst_busy (rst_busy)
  );

  always_comb begin
    if (tmpl.field == 2'd0) lane_sel = LANE_X1;
    else if (ctl_dual)      lane_sel = LANE_X2;
    else                    lane_sel = LANE_X4;
  end

  always_comb begin
    accept = win_rd && !busy_q && !rdy_q;
    start  = accept && mem_on && !rst_busy && !rst_req;
    quick  = accept && !start;
  end

  always_comb begin
    rdy_d  = 1'b0;
    zero_d = zero_q;
    busy_d = busy_q;
    if (quick) begin
      rdy_d  = 1'b1;
      zero_d = 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
    end
    if (busy_q && rst_req) begin
      rdy_d  = 1'b1;
      zero_d = 1'b1;
      busy_d = 1'b0;
    end else if (busy_q && done) begin
      rdy_d  = 1'b1;
      zero_d = 1'b0;
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      zero_q <= 1'b1;
    end else begin
      busy_q <= busy_d;
      rdy_q  <= rdy_d;
      zero_q <= zero_d;
    end
  end

  xip_frame_seq #(.ADDR_W(FL_AW), .DATA_BITS(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .abort      (rst_req),
    .opcode     (tmpl.opcode),
    .addr_bytes (tmpl.frame - 3'd1),
    .gap_bytes  (tmpl.ilen),
    .lane       (lane_sel),
    .addr       (FL_AW'(win_addr)),
    .lane_o     (lane_run),
    .smp_en     (smp_en),
    .done       (done),
    .sck        (fl_sck),
    .cs_n       (fl_cs_n),
    .io_out     (fl_io_out),
    .io_oe      (fl_io_oe)
  );

  xip_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (smp_en),
    .lane   (lane_run),
    .io_in  (fl_io_in),
    .word   (word)
  );

  assign win_ready = rdy_q;
  assign win_rdata = (rdy_q && !zero_q) ? word : '0;
  assign status    = {3'b000, rst_busy, 3'b000, mem_on};

endmodule

// File: rtl/xip_read_engine_chk.sv
`timescale 1ns/1ps
module xip_read_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       win_ready,
  input logic       fl_sck,
  input logic       fl_cs_n,
  input logic [3:0] fl_io_oe
);

  a_r13_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> (fl_io_oe == 4'b0000));

  a_r13_single_lane_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fl_io_oe) <= 1);

  a_r5_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sck);

  a_r5_sck_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_sck && !fl_cs_n) |=> !fl_sck);

  a_r9_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |=> !win_ready);

  a_r9_ready_frame_closed: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> fl_cs_n);

  a_r10_bits_clear_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> !status[0]);

  a_r4_no_frame_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> fl_cs_n);

  a_r11_abort_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> fl_cs_n);

endmodule

bind xip_read_engine xip_read_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .status    (status),
  .win_ready (win_ready),
  .fl_sck    (fl_sck),
  .fl_cs_n   (fl_cs_n),
  .fl_io_oe  (fl_io_oe)
);

// File: tb/sim_xip_read_engine.sv
`timescale 1ns/1ps
module sim_xip_read_engine;

  localparam int WIN_AW = 24;
  localparam int DATA_W = 32;
  localparam int RST_CYC = 4;

  logic              clk;
  logic              rst_n;
  logic              mcmd_wr;
  logic [15:0]       mcmd_word;
  logic              ctl_dual;
  logic              rst_req;
  logic [7:0]        status;
  logic              win_rd;
  logic [WIN_AW-1:0] win_addr;
  logic [DATA_W-1:0] win_rdata;
  logic              win_ready;
  logic              fl_sck, fl_cs_n;
  logic [3:0]        fl_io_out, fl_io_oe, fl_io_in;

  int n_chk = 0;
  int n_err = 0;

  xip_read_engine #(.WIN_AW(WIN_AW), .DATA_W(DATA_W), .RST_CYCLES(RST_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .mcmd_wr(mcmd_wr), .mcmd_word(mcmd_word),
    .ctl_dual(ctl_dual), .rst_req(rst_req), .status(status),
    .win_rd(win_rd), .win_addr(win_addr), .win_rdata(win_rdata),
    .win_ready(win_ready), .fl_sck(fl_sck), .fl_cs_n(fl_cs_n),
    .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe), .fl_io_in(fl_io_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0]  m_op;
  int          m_ab, m_il, m_lane;
  int          m_n;
  logic [31:0] m_addr;
  logic [7:0]  m_opc;
  int          oe_bad = 0;
  int          cs_falls = 0;

  function automatic logic [7:0] dbyte(input logic [31:0] a);
    return (a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h96) + a[23:16];
  endfunction

  function automatic logic [3:0] chunk(input int c);
    int w, p, hi;
    logic [7:0] bv;
    w  = 1 << m_lane;
    p  = c * w;
    hi = 7 - (p % 8);
    bv = (m_opc == m_op) ? dbyte(m_addr + 32'(p / 8)) : 8'hFF;
    case (m_lane)
      0:       return {2'b00, bv[hi], 1'b0};
      1:       return {2'b00, bv[hi], bv[hi-1]};
      default: return {bv[hi], bv[hi-1], bv[hi-2], bv[hi-3]};
    endcase
  endfunction

  always @(negedge fl_cs_n) begin
    m_n = 0; m_addr = '0; m_opc = '0; cs_falls++;
  end

  always @(posedge fl_sck) begin
    if (!fl_cs_n) begin
      if (m_n < 8 + 8*m_ab + 8*m_il) begin
        if (fl_io_oe !== 4'b0001) oe_bad++;
      end else if (fl_io_oe !== 4'b0000) oe_bad++;
      if (m_n < 8) m_opc = {m_opc[6:0], fl_io_out[0]};
      else if (m_n < 8 + 8*m_ab) m_addr = {m_addr[30:0], fl_io_out[0]};
      m_n++;
    end
  end

  always @(negedge fl_sck) begin
    if (!fl_cs_n && (m_n >= 8 + 8*m_ab + 8*m_il))
      fl_io_in <= chunk(m_n - (8 + 8*m_ab + 8*m_il));
  end

  // ---------------- scoreboard ----------------
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always @(negedge clk) begin
    if (rst_n && win_ready) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected ready", 64'(win_rdata), 64'hDEAD);
      end else begin
        check(tag_q.pop_front(), 64'(win_rdata), 64'(exp_q.pop_front()));
      end
    end
  end

  function automatic logic [DATA_W-1:0] exp_word(input logic [31:0] a, input int ab);
    logic [31:0] ae;
    logic [DATA_W-1:0] r;
    ae = (ab >= 4) ? a : (a & ((32'd1 << (8*ab)) - 32'd1));
    for (int k = 0; k < DATA_W/8; k++) r[8*k +: 8] = dbyte(ae + 32'(k));
    return r;
  endfunction

  function automatic logic [15:0] mk(input logic [7:0] op, input logic [2:0] fr,
                                     input logic [1:0] fd, input logic [2:0] il);
    return {op, fr, fd, il};
  endfunction

  task automatic do_read(input logic [WIN_AW-1:0] a, input logic [DATA_W-1:0] e,
                         input string tag, output int lat);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    win_addr = a;
    win_rd   = 1'b1;
    lat      = 0;
    do begin
      @(posedge clk); lat++; #1;
    end while (!win_ready && lat < 3000);
    @(negedge clk);
    win_rd = 1'b0;
  endtask

  task automatic wr_tmpl(input logic [15:0] w);
    @(negedge clk);
    mcmd_word = w; mcmd_wr = 1'b1;
    @(negedge clk);
    mcmd_wr = 1'b0;
  endtask

  task automatic do_reset_req();
    @(negedge clk); rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (status[4] && g < 100) begin @(negedge clk); g++; end
  endtask

  function automatic int frame_lat(input int ab, input int il, input int ln);
    return 2 * (8 + 8*ab + 8*il + (DATA_W >> ln)) + 1;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int lat, hi_cnt, cf;
    rst_n = 1'b0; mcmd_wr = 1'b0; mcmd_word = '0; ctl_dual = 1'b1;
    rst_req = 1'b0; win_rd = 1'b0; win_addr = '0; fl_io_in = '0;
    m_op = 8'h0B; m_ab = 3; m_il = 1; m_lane = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", 64'(status), 64'h0);
    check("R1 cs_n", 64'(fl_cs_n), 64'h1);
    check("R1 sck", 64'(fl_sck), 64'h0);
    check("R1 oe", 64'(fl_io_oe), 64'h0);
    check("R1 ready", 64'(win_ready), 64'h0);

    // R4 read while off
    cf = cs_falls;
    do_read(24'h000100, '0, "R4 data off", lat);
    check("R4 latency", 64'(lat), 64'd1);
    check("R4 no frame", 64'(cs_falls - cf), 64'd0);

    // R3 invalid words
    wr_tmpl(mk(8'h0B, 3'd1, 2'd0, 3'd0));
    check("R3 opcode-only rejected", 64'(status[0]), 64'h0);
    wr_tmpl(mk(8'h0B, 3'd6, 2'd0, 3'd0));
    check("R3 frame 6 rejected", 64'(status[0]), 64'h0);
    wr_tmpl(mk(8'h0B, 3'd4, 2'd2, 3'd0));
    check("R3 field 2 rejected", 64'(status[0]), 64'h0);
    do_read(24'h000200, '0, "R3 read after reject", lat);

    // R2 arm serial: 3 address bytes, 1 intermediate byte
    wr_tmpl(mk(8'h0B, 3'd4, 2'd0, 3'd1));
    check("R2 mode on", 64'(status), 64'h01);
    do_read(24'h123456, exp_word(32'h123456, 3), "R5 R6 R7 serial data", lat);
    check("R9 serial latency", 64'(lat), 64'(frame_lat(3, 1, 0)));
    do_read(24'h00ABCD, exp_word(32'h00ABCD, 3), "R8 little-endian", lat);

    // R12 write while active ignored
    wr_tmpl(mk(8'h3B, 3'd5, 2'd1, 3'd0));
    check("R12 status unchanged", 64'(status), 64'h01);
    do_read(24'h345678, exp_word(32'h345678, 3), "R12 old template used", lat);
    check("R12 old latency", 64'(lat), 64'(frame_lat(3, 1, 0)));

    // R10 reset handshake
    do_reset_req();
    check("R10 busy set", 64'(status), 64'h11);
    hi_cnt = 0;
    while (status[4] && hi_cnt < 50) begin hi_cnt++; @(negedge clk); end
    check("R10 busy length", 64'(hi_cnt), 64'(RST_CYC));
    check("R10 both clear", 64'(status), 64'h00);

    // R7 dual: 4 address bytes, no intermediate
    ctl_dual = 1'b1;
    m_op = 8'hBB; m_ab = 4; m_il = 0; m_lane = 1;
    wr_tmpl(mk(8'hBB, 3'd5, 2'd1, 3'd0));
    check("R2 dual armed", 64'(status[0]), 64'h1);
    do_read(24'hFEDCBA, exp_word(32'h00FEDCBA, 4), "R7 dual data", lat);
    check("R7 dual latency", 64'(lat), 64'(frame_lat(4, 0, 1)));
    do_reset_req();
    wait_idle();

    // R7 quad: 1 address byte, 4 intermediate bytes, truncated address (R5)
    ctl_dual = 1'b0;
    m_op = 8'h6B; m_ab = 1; m_il = 4; m_lane = 2;
    wr_tmpl(mk(8'h6B, 3'd2, 2'd1, 3'd4));
    do_read(24'h1234A7, exp_word(32'h1234A7, 1), "R5 R7 quad one-byte address", lat);
    check("R6 quad latency", 64'(lat), 64'(frame_lat(1, 4, 2)));

    // R12 write during pending reset ignored
    @(negedge clk); rst_req = 1'b1;
    @(negedge clk); rst_req = 1'b0; mcmd_word = mk(8'h0B, 3'd4, 2'd0, 3'd0); mcmd_wr = 1'b1;
    @(negedge clk); mcmd_wr = 1'b0;
    wait_idle();
    check("R12 write during reset ignored", 64'(status[0]), 64'h0);

    // R11 reset during a frame
    ctl_dual = 1'b1;
    m_op = 8'h0B; m_ab = 3; m_il = 1; m_lane = 0;
    wr_tmpl(mk(8'h0B, 3'd4, 2'd0, 3'd1));
    fork
      do_read(24'h0F0F0F, '0, "R11 abort zero data", lat);
      begin
        repeat (12) @(negedge clk);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        check("R11 cs high after abort", 64'(fl_cs_n), 64'h1);
      end
    join
    check("R11 short latency", 64'(lat < 20), 64'h1);
    wait_idle();

    check("R13 drive only in header", 64'(oe_bad), 64'h0);
    check("R9 scoreboard drained", 64'(exp_q.size()), 64'h0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule